// File: doc/BRIEF.md
# CPU Interrupt Pending and Priority Selector

This block sits beside a processor core and gathers level-style hardware interrupt requests from nine sources into a pending register. Each source can be raised or dropped through its own set and clear lines, and events coming from an external programmable interrupt controller are translated onto the same pending bits. A summary request line reports that anything at all is pending. A wake line tells a halted core when it may resume.

When the core asserts the take input, the block picks one exception with a fixed priority. The critical input is never masked. The machine check is gated by the machine-check enable. The timer and external sources are gated by the external enable. The block reports the pick as a one-cycle valid strobe with a 4-bit code. On that same clock edge it clears the pending bit of the chosen source and leaves every other pending bit alone. A core-reset event from the interrupt controller does not become a pending source. It produces a one-cycle system reset request.

Top module: `cpu_irq_arbiter`

## Requirements
- R1: A pulse on `src_set_i[k]` sets pending bit k, and `hard_req_o` is 1 from the next clock edge.
- R2: A pulse on `src_clr_i[k]` clears pending bit k. `hard_req_o` falls only once no pending bit remains.
- R3: Pending bit 0 (critical input) is chosen first on a take, with code 0, whatever the values of `me_i` and `ee_i`.
- R4: Pending bit 1 (machine check) is chosen with code 1 only when `me_i` is 1 and bit 0 is not pending.
- R5: With `ee_i` at 1 and nothing higher pending, the search order is: bit 4 (hypervisor decrementer, code 4), bit 3 (decrementer, code 3), bit 5 (interval timer, code 5), bit 6 (fixed interval timer, code 6), bit 7 (watchdog, code 7), bit 2 (external, code 2).
- R6: `sel_valid_o` and `sel_code_o` appear for one cycle after the edge on which `take_i` was 1. That edge clears only the chosen bit. A take with nothing selectable gives no valid strobe.
- R7: Bit 8 (debug) is held as pending and keeps `hard_req_o` high, but it is never chosen.
- R8: When `pic_evt_vld_i` is 1, `pic_evt_i` is decoded as 0 = normal (bit 2), 1 = critical (bit 0), 2 = machine check (bit 1), 3 = debug (bit 8). `pic_lvl_i` set to 1 sets the mapped bit, and set to 0 clears it.
- R9: `pic_evt_i` = 4 (core reset) with `pic_lvl_i` at 1 drives `sys_rst_req_o` high for exactly the one following cycle and sets no pending bit.
- R10: `wake_o` is 1 only while `ee_i` is 1 and `hard_req_o` is 1.
- R11: When a set and a take-clear hit the same bit in one cycle, the bit stays pending.
- R12: After reset the pending register is empty and all outputs are 0.
- R13: With parameter `HYP_EN` = 0, bit 4 never takes part in selection but still counts toward `hard_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_set_i | input | 9 | Per-source raise request |
| src_clr_i | input | 9 | Per-source drop request |
| pic_evt_vld_i | input | 1 | Interrupt controller event strobe |
| pic_evt_i | input | 3 | Interrupt controller event kind |
| pic_lvl_i | input | 1 | Event level: 1 raise, 0 drop |
| me_i | input | 1 | Machine-check enable |
| ee_i | input | 1 | External enable |
| take_i | input | 1 | Core takes the next exception |
| sel_valid_o | output | 1 | Selection strobe |
| sel_code_o | output | 4 | Selected exception code |
| hard_req_o | output | 1 | Summary request: any bit pending |
| wake_o | output | 1 | Wake request for a halted core |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A set, a clear or a mapped event first shows on `hard_req_o` one edge after it is driven. The selection strobe and code belong to the edge that sampled `take_i`, so they are due one cycle after the take. `sys_rst_req_o` is registered and also lags its event by one edge. `wake_o` follows `ee_i` at once, with no added delay. The bench drives every input just after a falling edge. A scoreboard queue records the expected code for each take. The monitor pops that entry at the falling edge after the take's rising edge and compares it there. Level checks on the other outputs are made at falling edges as well, never at the active edge.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int unsigned NSRC   = 9;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned EVT_W  = 3;

  typedef enum logic [CODE_W-1:0] {
    SRC_CRIT = 4'd0,
    SRC_MCHK = 4'd1,
    SRC_EXT  = 4'd2,
    SRC_DEC  = 4'd3,
    SRC_HDEC = 4'd4,
    SRC_PIT  = 4'd5,
    SRC_FIT  = 4'd6,
    SRC_WDOG = 4'd7,
    SRC_DBG  = 4'd8
  } src_e;

  typedef enum logic [EVT_W-1:0] {
    EVT_NORM = 3'd0,
    EVT_CRIT = 3'd1,
    EVT_MCHK = 3'd2,
    EVT_DBG  = 3'd3,
    EVT_CRST = 3'd4
  } pic_evt_e;
endpackage

// File: rtl/irq_pic_map.sv
module irq_pic_map
  import irq_sel_pkg::*;
(
  input  logic             vld_i,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             lvl_i,
  output logic [NSRC-1:0]  set_o,
  output logic [NSRC-1:0]  clr_o,
  output logic             crst_o
);
  logic [NSRC-1:0] hit;

  always_comb begin
    hit    = '0;
    crst_o = 1'b0;
    if (vld_i) begin
      unique case (evt_i)
        EVT_NORM: hit[SRC_EXT]  = 1'b1;
        EVT_CRIT: hit[SRC_CRIT] = 1'b1;
        EVT_MCHK: hit[SRC_MCHK] = 1'b1;
        EVT_DBG:  hit[SRC_DBG]  = 1'b1;
        EVT_CRST: crst_o        = lvl_i;
        default:  ;
      endcase
    end
  end

  assign set_o = lvl_i ? hit : '0;
  assign clr_o = lvl_i ? '0  : hit;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_sel_pkg::*;
#(
  parameter bit HYP_EN = 1'b1
) (
  input  logic [NSRC-1:0]   pend_i,
  input  logic              me_i,
  input  logic              ee_i,
  output logic              found_o,
  output logic [CODE_W-1:0] code_o,
  output logic [NSRC-1:0]   grant_o
);
  logic hdec_ok;

  generate
    if (HYP_EN) begin : g_hyp
      assign hdec_ok = pend_i[SRC_HDEC];
    end else begin : g_nohyp
      assign hdec_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    found_o = 1'b1;
    code_o  = SRC_CRIT;
    if (pend_i[SRC_CRIT])                code_o = SRC_CRIT;
    else if (me_i && pend_i[SRC_MCHK])   code_o = SRC_MCHK;
    else if (ee_i && hdec_ok)            code_o = SRC_HDEC;
    else if (ee_i && pend_i[SRC_DEC])    code_o = SRC_DEC;
    else if (ee_i && pend_i[SRC_PIT])    code_o = SRC_PIT;
    else if (ee_i && pend_i[SRC_FIT])    code_o = SRC_FIT;
    else if (ee_i && pend_i[SRC_WDOG])   code_o = SRC_WDOG;
    else if (ee_i && pend_i[SRC_EXT])    code_o = SRC_EXT;
    else                                 found_o = 1'b0;
  end

  always_comb begin
    grant_o = '0;
    if (found_o) grant_o[code_o] = 1'b1;
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_sel_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  // set beats clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/cpu_irq_arbiter.sv
module cpu_irq_arbiter
  import irq_sel_pkg::*;
#(
  parameter bit HYP_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_set_i,
  input  logic [NSRC-1:0]   src_clr_i,
  input  logic              pic_evt_vld_i,
  input  logic [EVT_W-1:0]  pic_evt_i,
  input  logic              pic_lvl_i,
  input  logic              me_i,
  input  logic              ee_i,
  input  logic              take_i,
  output logic              sel_valid_o,
  output logic [CODE_W-1:0] sel_code_o,
  output logic              hard_req_o,
  output logic              wake_o,
  output logic              sys_rst_req_o
);
  logic [NSRC-1:0]   pic_set, pic_clr, grant, pend;
  logic [NSRC-1:0]   set_all, clr_all;
  logic              crst, found;
  logic [CODE_W-1:0] code;

  irq_pic_map u_map (
    .vld_i  (pic_evt_vld_i),
    .evt_i  (pic_evt_i),
    .lvl_i  (pic_lvl_i),
    .set_o  (pic_set),
    .clr_o  (pic_clr),
    .crst_o (crst)
  );

  irq_prio_sel #(.HYP_EN(HYP_EN)) u_sel (
    .pend_i  (pend),
    .me_i    (me_i),
    .ee_i    (ee_i),
    .found_o (found),
    .code_o  (code),
    .grant_o (grant)
  );

  assign set_all = src_set_i | pic_set;
  assign clr_all = src_clr_i | pic_clr | (take_i ? grant : '0);

  irq_pend_reg u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_all),
    .clr_i  (clr_all),
    .pend_o (pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_valid_o   <= 1'b0;
      sel_code_o    <= '0;
      sys_rst_req_o <= 1'b0;
    end else begin
      sel_valid_o   <= take_i & found;
      sel_code_o    <= (take_i & found) ? code : '0;
      sys_rst_req_o <= crst;
    end
  end

  assign hard_req_o = |pend;
  assign wake_o     = ee_i & hard_req_o;
endmodule

// File: rtl/cpu_irq_arbiter_chk.sv
module cpu_irq_arbiter_chk
  import irq_sel_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NSRC-1:0]   src_set_i,
  input logic              pic_evt_vld_i,
  input logic [EVT_W-1:0]  pic_evt_i,
  input logic              pic_lvl_i,
  input logic              me_i,
  input logic              take_i,
  input logic [NSRC-1:0]   pend,
  input logic              sel_valid_o,
  input logic [CODE_W-1:0] sel_code_o,
  input logic              hard_req_o,
  input logic              sys_rst_req_o
);
  a_r1_set_raises_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_set_i) |=> hard_req_o);

  a_r6_valid_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_valid_o) |-> $past(take_i));

  a_r3_crit_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && pend[SRC_CRIT]) |=> (sel_valid_o && sel_code_o == SRC_CRIT));

  a_r4_mchk_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_valid_o && sel_code_o == SRC_MCHK) |-> $past(me_i));

  a_r7_no_debug: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> sel_code_o != SRC_DBG);

  a_r9_crst_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_req_o) |-> $past(pic_evt_vld_i && pic_evt_i == EVT_CRST && pic_lvl_i));
endmodule

bind cpu_irq_arbiter cpu_irq_arbiter_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .src_set_i     (src_set_i),
  .pic_evt_vld_i (pic_evt_vld_i),
  .pic_evt_i     (pic_evt_i),
  .pic_lvl_i     (pic_lvl_i),
  .me_i          (me_i),
  .take_i        (take_i),
  .pend          (pend),
  .sel_valid_o   (sel_valid_o),
  .sel_code_o    (sel_code_o),
  .hard_req_o    (hard_req_o),
  .sys_rst_req_o (sys_rst_req_o)
);

// File: tb/tb_cpu_irq_arbiter.sv
module tb_cpu_irq_arbiter;
  import irq_sel_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_set = '0, src_clr = '0;
  logic pic_vld = 1'b0, pic_lvl = 1'b0;
  logic [EVT_W-1:0] pic_evt = '0;
  logic me = 1'b0, ee = 1'b0, take = 1'b0;
  logic sel_valid, hard_req, wake, sys_rst;
  logic [CODE_W-1:0] sel_code;
  logic nh_valid, nh_req, nh_wake, nh_rst;
  logic [CODE_W-1:0] nh_code;

  int n_cmp = 0, n_bad = 0;
  int exp_q[$];
  logic took = 1'b0;

  always #10 clk = ~clk;

  cpu_irq_arbiter #(.HYP_EN(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .src_set_i(src_set), .src_clr_i(src_clr),
    .pic_evt_vld_i(pic_vld), .pic_evt_i(pic_evt), .pic_lvl_i(pic_lvl),
    .me_i(me), .ee_i(ee), .take_i(take),
    .sel_valid_o(sel_valid), .sel_code_o(sel_code), .hard_req_o(hard_req),
    .wake_o(wake), .sys_rst_req_o(sys_rst));

  cpu_irq_arbiter #(.HYP_EN(1'b0)) dut_nohv (
    .clk_i(clk), .rst_ni(rst_n), .src_set_i(src_set), .src_clr_i(src_clr),
    .pic_evt_vld_i(pic_vld), .pic_evt_i(pic_evt), .pic_lvl_i(pic_lvl),
    .me_i(me), .ee_i(ee), .take_i(take),
    .sel_valid_o(nh_valid), .sel_code_o(nh_code), .hard_req_o(nh_req),
    .wake_o(nh_wake), .sys_rst_req_o(nh_rst));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: result of a take is due one edge later
  always @(posedge clk) took <= take;
  always @(negedge clk) begin
    if (took) begin
      int e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : -2;
      if (e < 0) chk(!sel_valid, "R6 take with nothing selectable", int'(sel_valid), 0);
      else chk(sel_valid && int'(sel_code) == e, "R5/R6 selection code",
               sel_valid ? int'(sel_code) : -1, e);
    end else begin
      chk(!sel_valid, "R6 strobe only after take", int'(sel_valid), 0);
    end
  end

  // all tasks start and end just after a falling edge
  task automatic pulse(input logic [NSRC-1:0] s, input logic [NSRC-1:0] c);
    src_set = s; src_clr = c;
    @(negedge clk);
    src_set = '0; src_clr = '0;
  endtask

  task automatic take_exp(input int code, input logic [NSRC-1:0] s = '0);
    exp_q.push_back(code);
    take = 1'b1; src_set = s;
    @(negedge clk);
    take = 1'b0; src_set = '0;
  endtask

  task automatic pic(input logic [EVT_W-1:0] e, input logic l);
    pic_vld = 1'b1; pic_evt = e; pic_lvl = l;
    @(negedge clk);
    pic_vld = 1'b0; pic_lvl = 1'b0;
  endtask

  initial begin
    #(20 * 5000);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R12
    chk(!hard_req && !sel_valid && !wake && !sys_rst, "R12 reset outputs",
        int'({hard_req, sel_valid, wake, sys_rst}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!hard_req, "R12 empty after reset", int'(hard_req), 0);

    // R1, R10
    pulse(9'h008, '0);
    chk(hard_req, "R1 set raises request", int'(hard_req), 1);
    chk(!wake, "R10 no wake with ee=0", int'(wake), 0);
    ee = 1'b1; #1;
    chk(wake, "R10 wake with ee=1", int'(wake), 1);
    take_exp(3);
    chk(!hard_req, "R6 last take clears request", int'(hard_req), 0);

    // R5 order
    pulse(9'h0FC, '0);
    take_exp(4); take_exp(3); take_exp(5); take_exp(6); take_exp(7);
    chk(hard_req, "R6 other bits remain pending", int'(hard_req), 1);
    take_exp(2);
    take_exp(-1);
    chk(!hard_req, "R2 request drops when empty", int'(hard_req), 0);

    // R2
    pulse(9'h024, '0);
    pulse('0, 9'h004);
    chk(hard_req, "R2 request held with one bit left", int'(hard_req), 1);
    pulse('0, 9'h020);
    chk(!hard_req, "R2 request drops after last clear", int'(hard_req), 0);

    // R3, R4
    ee = 1'b0; me = 1'b0;
    pulse(9'h00B, '0);
    take_exp(0);
    take_exp(-1);
    me = 1'b1;
    take_exp(1);
    chk(hard_req, "R6 decrementer still pending", int'(hard_req), 1);
    ee = 1'b1;
    take_exp(3);
    chk(!hard_req, "R6 all taken", int'(hard_req), 0);

    // R7
    pulse(9'h100, '0);
    take_exp(-1);
    chk(hard_req, "R7 debug stays pending", int'(hard_req), 1);
    pulse('0, 9'h100);
    chk(!hard_req, "R7 debug cleared", int'(hard_req), 0);

    // R8
    pic(3'd0, 1'b1); take_exp(2);
    pic(3'd1, 1'b1); take_exp(0);
    pic(3'd2, 1'b1); take_exp(1);
    pic(3'd3, 1'b1);
    chk(hard_req, "R8 debug event pends", int'(hard_req), 1);
    take_exp(-1);
    pic(3'd3, 1'b0);
    chk(!hard_req, "R8 debug event drop clears", int'(hard_req), 0);
    pic(3'd0, 1'b1); pic(3'd0, 1'b0);
    chk(!hard_req, "R8 normal event drop clears", int'(hard_req), 0);

    // R9
    pic(3'd4, 1'b1);
    chk(sys_rst, "R9 reset request pulse", int'(sys_rst), 1);
    chk(!hard_req, "R9 no pending bit", int'(hard_req), 0);
    @(negedge clk);
    chk(!sys_rst, "R9 pulse one cycle", int'(sys_rst), 0);

    // R11
    pulse(9'h008, '0);
    take_exp(3, 9'h008);
    chk(hard_req, "R11 set wins over take", int'(hard_req), 1);
    take_exp(3);
    chk(!hard_req, "R11 second take empties", int'(hard_req), 0);

    // R13: no-hypervisor variant ignores bit 4 in selection
    pulse(9'h018, '0);
    take_exp(4);
    chk(nh_valid && nh_code == 4'd3, "R13 no-hyp picks decrementer",
        int'(nh_code), 3);
    take_exp(3);
    chk(!nh_valid, "R13 no-hyp never picks bit 4", int'(nh_valid), 0);
    chk(nh_req, "R13 bit 4 still counts as pending", int'(nh_req), 1);
    pulse('0, 9'h010);
    chk(!nh_req && !hard_req, "R13 cleared", int'(nh_req), 0);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule